// File: doc/BRIEF.md
# External Interrupt Request Latch

This block is the external interrupt front end of a small 8-bit microcontroller. It watches an active-low interrupt pin and four port pins that can raise interrupts. It holds one pending request bit. It raises a request to the CPU only at instruction boundaries, and only while the global mask bit is clear and the local enable bit is set. The CPU clears the pending bit when it fetches the interrupt vector, so a second request can be captured while the service routine runs. Software can also clear the bit through a clear strobe.

The pin first passes through a two-stage synchronizer. The synchronized value drives a two-state tracker. In state ST_ARMED the pin was last seen high, so a low sample counts as a falling edge. That sets the request and moves the tracker to ST_LOW (transition FALL). In ST_LOW the tracker waits for a high sample and then returns to ST_ARMED (transition RISE). In edge-only mode the ST_LOW state never sets the request. In edge-and-level mode a low sample sets it in either state, so a wired-OR source that holds the line low keeps the request present. While the port-pin interrupts are enabled and any port pin is high, the tracker takes no transition and nothing is set.

Top module: `ext_irq_front`

## Requirements
- R1: After reset, irq_pending and irq_req are 0 and the tracker is in ST_ARMED. A pin that is low during reset is then seen as a falling edge.
- R2: In edge-only mode (level_mode=0), a falling edge on irq_pin_n sets irq_pending. It is visible on the third rising clock edge after the pin changes: two synchronizer stages, then the latch.
- R3: In edge-only mode, a pin held low after the latch is cleared does not set it again. A new request is latched only after the pin has been seen high and then falls again.
- R4: In edge-and-level mode (level_mode=1), a low pin sets irq_pending on every cycle. A clear made while the pin is still low therefore leaves irq_pending at 1.
- R5: irq_req is 1 exactly when instr_done=1, irq_pending=1, cpu_imask=0 and irq_enable=1. It is combinational from these inputs.
- R6: vec_fetch_ack=1 clears irq_pending at the next clock edge. A falling edge that arrives after the acknowledge sets irq_pending again.
- R7: sw_clear=1 clears irq_pending at the next clock edge. If a set and a clear (sw_clear or vec_fetch_ack) fall in the same cycle, irq_pending becomes 1.
- R8: While port_irq_en=1 and any bit of port_pins is 1, pin changes and pin level set nothing, and the tracker keeps its state. When all port pins return low, a pin that went low during the block is treated as a falling edge on the next clock edge.
- R9: level_mode is static. It is changed only while rst_n is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_pin_n | input | 1 | Active-low interrupt pin (asynchronous) |
| level_mode | input | 1 | 1 = edge-and-level, 0 = edge-only (static) |
| port_irq_en | input | 1 | Port-pin interrupts enabled |
| port_pins | input | 4 | Synchronized port pin levels |
| cpu_imask | input | 1 | Global interrupt mask bit (1 = masked) |
| irq_enable | input | 1 | Local pin-interrupt enable |
| instr_done | input | 1 | Current instruction completes this cycle |
| vec_fetch_ack | input | 1 | CPU fetches the interrupt vector |
| sw_clear | input | 1 | Software clear strobe for the latch |
| irq_req | output | 1 | Interrupt request to the CPU |
| irq_pending | output | 1 | Request latch state |

## Verification
The assertions take level_mode to be constant outside reset. They take port_pins to be already synchronous to clk, and sw_clear and vec_fetch_ack to be single-cycle strobes driven from registers. The bench drives every input on the falling clock edge and changes level_mode only while reset is held. Port pins move only between full clock periods, so every expected value can be placed on an exact cycle.

// File: rtl/irq_front_pkg.sv
package irq_front_pkg;
    typedef enum logic [0:0] {
        ST_ARMED = 1'b0,
        ST_LOW   = 1'b1
    } pin_state_t;
endpackage

// File: rtl/irq_pin_sync.sv
module irq_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);
    logic [STAGES-1:0] chain_q;

    // Stages reset to 1, the idle level of an active-low pin.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= {chain_q[STAGES-2:0], async_in};
    end

    assign sync_out = chain_q[STAGES-1];
endmodule

// File: rtl/irq_edge_fsm.sv
module irq_edge_fsm
    import irq_front_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pin_s,
    input  logic level_mode,
    input  logic blocked,
    output logic set_req
);
    pin_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_ARMED;
        else        state_q <= state_d;
    end

    // Next state: FALL (ARMED->LOW) and RISE (LOW->ARMED), frozen while blocked.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_ARMED: if (!blocked && !pin_s) state_d = ST_LOW;
            ST_LOW:   if (!blocked &&  pin_s) state_d = ST_ARMED;
            default:  state_d = ST_ARMED;
        endcase
    end

    // Output: set on a falling edge, or on a low level in level mode.
    always_comb begin
        set_req = 1'b0;
        unique case (state_q)
            ST_ARMED: set_req = !blocked && !pin_s;
            ST_LOW:   set_req = level_mode && !blocked && !pin_s;
            default:  set_req = 1'b0;
        endcase
    end

    // R3: in edge-only mode, no two sets happen in consecutive cycles.
    p_edge_once_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (set_req && !level_mode) |=> !set_req);

    // R8: the state is held while blocked.
    p_block_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        blocked |=> (state_q == $past(state_q)));
endmodule

// File: rtl/irq_req_latch.sv
module irq_req_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic set_req,
    input  logic clr_req,
    output logic pending
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       pending <= 1'b0;
        else if (set_req) pending <= 1'b1;
        else if (clr_req) pending <= 1'b0;
    end

    // R7: a set wins over a clear in the same cycle.
    p_set_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
        set_req |=> pending);

    // R6: a clear without a set empties the latch.
    p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_req && !set_req) |=> !pending);

    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_req && !set_req) |=> $stable(pending));
endmodule

// File: rtl/ext_irq_front.sv
module ext_irq_front #(
    parameter int SYNC_STAGES   = 2,
    parameter int NUM_PORT_PINS = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     irq_pin_n,
    input  logic                     level_mode,
    input  logic                     port_irq_en,
    input  logic [NUM_PORT_PINS-1:0] port_pins,
    input  logic                     cpu_imask,
    input  logic                     irq_enable,
    input  logic                     instr_done,
    input  logic                     vec_fetch_ack,
    input  logic                     sw_clear,
    output logic                     irq_req,
    output logic                     irq_pending
);
    logic pin_s;
    logic blocked;
    logic set_req;
    logic clr_req;

    irq_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (irq_pin_n),
        .sync_out (pin_s)
    );

    assign blocked = port_irq_en && (|port_pins);
    assign clr_req = vec_fetch_ack || sw_clear;

    irq_edge_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .pin_s      (pin_s),
        .level_mode (level_mode),
        .blocked    (blocked),
        .set_req    (set_req)
    );

    irq_req_latch u_latch (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_req (set_req),
        .clr_req (clr_req),
        .pending (irq_pending)
    );

    assign irq_req = instr_done && irq_pending && !cpu_imask && irq_enable;

    // R5: a masked or disabled interrupt, or one outside a boundary, is never requested.
    p_mask_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_imask || !irq_enable || !instr_done) |-> !irq_req);

    // R8: a block with an empty latch keeps it empty.
    p_port_block_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (port_irq_en && (|port_pins) && !irq_pending) |=> !irq_pending);

    // R9: the mode does not change outside reset.
    p_static_mode_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(level_mode));
endmodule

// File: tb/tb_ext_irq_front.sv
module tb_ext_irq_front;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       irq_pin_n = 1'b1;
    logic       level_mode = 1'b0;
    logic       port_irq_en = 1'b0;
    logic [3:0] port_pins = 4'b0;
    logic       cpu_imask = 1'b0;
    logic       irq_enable = 1'b1;
    logic       instr_done = 1'b0;
    logic       vec_fetch_ack = 1'b0;
    logic       sw_clear = 1'b0;
    logic       irq_req;
    logic       irq_pending;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    ext_irq_front dut (
        .clk(clk), .rst_n(rst_n), .irq_pin_n(irq_pin_n), .level_mode(level_mode),
        .port_irq_en(port_irq_en), .port_pins(port_pins), .cpu_imask(cpu_imask),
        .irq_enable(irq_enable), .instr_done(instr_done), .vec_fetch_ack(vec_fetch_ack),
        .sw_clear(sw_clear), .irq_req(irq_req), .irq_pending(irq_pending)
    );

    // Table for R5: {instr_done, cpu_imask, irq_enable, expected irq_req}, latch set.
    localparam logic [3:0] R5_TABLE [8] = '{
        4'b0000, 4'b0010, 4'b0100, 4'b0110,
        4'b1000, 4'b1011, 4'b1100, 4'b1110
    };

    task automatic check(input logic got, input logic exp, input string req);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0b expected %0b", req, got, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_ack();
        vec_fetch_ack = 1'b1; cyc(1); vec_fetch_ack = 1'b0;
    endtask

    task automatic pulse_clr();
        sw_clear = 1'b1; cyc(1); sw_clear = 1'b0;
    endtask

    task automatic do_reset(input logic lvl);
        rst_n = 1'b0; level_mode = lvl; cyc(2); rst_n = 1'b1; cyc(1);
    endtask

    initial begin
        do_reset(1'b0);
        // R1 reset state
        check(irq_pending, 1'b0, "R1 pending");
        check(irq_req, 1'b0, "R1 req");

        // R2 falling edge sets after three edges
        irq_pin_n = 1'b0; cyc(2);
        check(irq_pending, 1'b0, "R2 not yet");
        cyc(1);
        check(irq_pending, 1'b1, "R2 set");

        // R6 ack clears; R3 held low does not re-set
        pulse_ack();
        check(irq_pending, 1'b0, "R6 ack clears");
        cyc(4);
        check(irq_pending, 1'b0, "R3 held low ignored");

        // R3 re-arm after high; R6 new request captured after ack
        irq_pin_n = 1'b1; cyc(3);
        irq_pin_n = 1'b0; cyc(3);
        check(irq_pending, 1'b1, "R3 rearm fall sets");
        check(irq_pending, 1'b1, "R6 captured after ack");

        // R5 table walk
        foreach (R5_TABLE[i]) begin
            instr_done = R5_TABLE[i][3];
            cpu_imask  = R5_TABLE[i][2];
            irq_enable = R5_TABLE[i][1];
            #1;
            check(irq_req, R5_TABLE[i][0], $sformatf("R5 row %0d", i));
            cyc(1);
        end
        instr_done = 1'b0; cpu_imask = 1'b0; irq_enable = 1'b1;

        // R7 software clear
        pulse_clr();
        check(irq_pending, 1'b0, "R7 sw clear");

        // R7 set wins over clear in the same cycle
        irq_pin_n = 1'b1; cyc(3);
        irq_pin_n = 1'b0; cyc(2);
        sw_clear = 1'b1; cyc(1); sw_clear = 1'b0;
        check(irq_pending, 1'b1, "R7 set wins");
        pulse_clr();
        irq_pin_n = 1'b1; cyc(3);

        // R8 port pin high blocks the pin
        port_irq_en = 1'b1; port_pins = 4'b0100;
        irq_pin_n = 1'b0; cyc(5);
        check(irq_pending, 1'b0, "R8 blocked");
        port_pins = 4'b0000; cyc(1);
        check(irq_pending, 1'b1, "R8 released edge");
        port_irq_en = 1'b0;
        pulse_clr();
        irq_pin_n = 1'b1; cyc(3);

        // R4 level mode
        do_reset(1'b1);
        check(irq_pending, 1'b0, "R1 pending level");
        irq_pin_n = 1'b0; cyc(3);
        check(irq_pending, 1'b1, "R4 low sets");
        pulse_ack();
        check(irq_pending, 1'b1, "R4 held low survives ack");
        irq_pin_n = 1'b1; cyc(2);
        pulse_ack();
        check(irq_pending, 1'b0, "R4 cleared after high");
        instr_done = 1'b1; #1;
        check(irq_req, 1'b0, "R5 no req when empty");
        instr_done = 1'b0;

        finished = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(20000 * 5);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end
endmodule